// File: doc/BRIEF.md
# Clock Generator Control Register Slave

This block is the two-wire control port of a clock generator. It watches the open-drain SDA and SCL lines, answers one write address and one read address, and keeps the bank of control bytes that set up the generator's outputs, spread modulation and PLL divider source. All transfers are block transfers. A write carries a command byte and then a byte-count byte. Both are acknowledged and both are discarded. The data bytes that follow go into register 0, 1, 2 and so on, in that order.

A read begins with a count byte sent by the slave. The slave then streams register 0 onward until the master answers with a NACK. Some bits are read-only and report live input pins. One of these is the PCI-stop bit, which reads back as the AND of its stored value and the active-low PCI-stop pin. Register 6 is a fixed signature. Reserved bits always read as zero. The stored image, the effective PCI run enable and the decoded PLL divider fields come out as ports for the clock logic. Both lines pass through two-flop synchronizers onto the system clock, so SCL must be well below the system clock rate.

Top module: `clkgen_ctl_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) and 0xD3 (read). For any other address it leaves SDA released for the rest of that transfer, and the registers keep their values.
- R2: In a write, the command byte and the byte-count byte are acknowledged and have no effect. Each data byte after them is acknowledged and stored into register 0, 1, 2 and onward, in order. Only the writable bits take the data.
- R3: In a read, the slave first sends a count byte equal to the number of registers (10). It then sends register 0, 1 and onward, moving on each time the master acknowledges. After the master's NACK it releases SDA.
- R4: Register 0 bits 2:0 report the three frequency-select pins and bit 4 reports the CPU-stop pin level. Register 1 bit 7 reports the current-multiplier select pin. Writes do not change these bits.
- R5: Register 0 bit 3 is writable. It reads back as (stored bit AND PCI-stop pin level), and output `pci_clk_run` carries the same value.
- R6: Register 6 always reads 0x13. A write to it is acknowledged and the data is dropped.
- R7: After reset the registers read: reg1 = 0x07 plus the multiplier pin in bit 7, reg2 = 0x7F, reg3 = 0xC7, reg4 = 0x3F, reg5 = 0x40. Every other writable bit is 0.
- R8: These bits are reserved and always read 0: reg4 bit 6, reg5 bits 3 and 1, all of reg7, and bit 7 of reg8 and reg9. Data bytes past register 9 are acknowledged and dropped. Reads past register 9 return 0x00.
- R9: `pll_custom` equals reg9 bit 0, `pll_n` equals reg8 bits 6:0, and `pll_r` equals reg9 bits 6:1.
- R10: A STOP at any point ends the transfer, and a partly received byte is not stored. A repeated START begins a new address phase.
- R11: The slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| fsel_pin | input | 3 | Frequency-select pin levels |
| cpu_stop_n_pin | input | 1 | CPU-stop pin level (active low) |
| pci_stop_n_pin | input | 1 | PCI-stop pin level (active low) |
| mult_pin | input | 1 | Current-multiplier select pin |
| cfg_image | output | NBYTES*8 (80) | Stored writable bits, register i at bits 8i+7:8i |
| pci_clk_run | output | 1 | Effective PCI run enable |
| pll_custom | output | 1 | 1 = PLL dividers come from registers |
| pll_n | output | 7 | PLL N value |
| pll_r | output | 6 | PLL R value |

## Verification
The assertions assume that SDA and SCL change far more slowly than the system clock. They also assume that the master changes SDA only while SCL is low, except when it forms a START or STOP, and that the master never tries a STOP while the slave is holding SDA low. The bench master holds every SCL phase for ten system clocks and moves SDA a full phase away from any SCL edge. It issues STOP and repeated START only after an acknowledge slot or a master NACK, when the slave has released the line.

// File: rtl/clkgen_ctl_pkg.sv
// Shared constants, state type and register layout tables for the
// clock generator control slave.
package clkgen_ctl_pkg;
    localparam int unsigned REG_BYTES = 10;
    localparam int unsigned SIG_INDEX = 6;
    localparam logic [7:0]  WR_ADDR   = 8'hD2;
    localparam logic [7:0]  RD_ADDR   = 8'hD3;
    localparam logic [7:0]  SIG_VALUE = 8'h13;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WDATA, ST_RDATA
    } smb_state_t;

    // Bits a data byte may change in each register.
    function automatic logic [7:0] wmask(int unsigned i);
        case (i)
            0: return 8'hE8;
            1: return 8'h7F;
            2: return 8'hFF;
            3: return 8'hFF;
            4: return 8'hBF;
            5: return 8'hF5;
            8: return 8'h7F;
            9: return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value of the stored bits of each register.
    function automatic logic [7:0] rst_val(int unsigned i);
        case (i)
            1: return 8'h07;
            2: return 8'h7F;
            3: return 8'hC7;
            4: return 8'h3F;
            5: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA onto the system clock through two flops each and
// derives SCL edges plus START and STOP conditions.
// Assumes both lines are slow compared with clk.
module smb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES-1:0] chain;
        // Synchronizer chain for one line, idle level high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[l]};
        end
        assign synced[l] = chain[STAGES-1];
    end

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/smb_block_engine.sv
// Byte-level engine: address decode, discard of command and count bytes,
// write pulses for data bytes, and the read stream (count byte, then
// registers from 0). Assumes synchronized lines from smb_line_sync.
module smb_block_engine
    import clkgen_ctl_pkg::*;
#(
    parameter int unsigned NBYTES = REG_BYTES,
    parameter int unsigned IDXW   = $clog2(NBYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    output logic            sda_oe,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic [IDXW-1:0] rd_idx,
    input  logic [7:0]      rd_data
);
    localparam logic [IDXW-1:0] IDX_END = IDXW'(NBYTES);
    localparam logic [7:0]      COUNT   = 8'(NBYTES);

    smb_state_t      state, after_ack;
    logic [3:0]      bitcnt;
    logic            in_ack;
    logic [7:0]      shreg, tx;
    logic [IDXW-1:0] idx;

    assign rd_idx = idx;

    // Transfer sequencing, advanced on SCL edges and bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; after_ack <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0;
            shreg <= '0; tx <= '0; idx <= '0; sda_oe <= 1'b0;
            wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state <= ST_ADDR; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
            end else if (state == ST_RDATA) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8) begin
                        tx <= {tx[6:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (sda_s) begin
                        state <= ST_IDLE;
                    end else begin
                        tx <= rd_data;
                        bitcnt <= '0;
                        if (idx != IDX_END) idx <= idx + 1'b1;
                    end
                end
                if (scl_fall) sda_oe <= (bitcnt < 4'd8) ? ~tx[7] : 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise && !in_ack && bitcnt < 4'd8) begin
                    shreg <= {shreg[6:0], sda_s};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (scl_fall && in_ack) begin
                    in_ack <= 1'b0; bitcnt <= '0; state <= after_ack;
                    if (after_ack == ST_RDATA) begin
                        tx <= COUNT; sda_oe <= ~COUNT[7];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end else if (scl_fall && bitcnt == 4'd8) begin
                    in_ack <= 1'b1; sda_oe <= 1'b1;
                    case (state)
                        ST_ADDR: begin
                            idx <= '0;
                            if (shreg == WR_ADDR)      after_ack <= ST_CMD;
                            else if (shreg == RD_ADDR) after_ack <= ST_RDATA;
                            else begin
                                state <= ST_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
                            end
                        end
                        ST_CMD: after_ack <= ST_CNT;
                        ST_CNT: begin after_ack <= ST_WDATA; idx <= '0; end
                        default: begin
                            after_ack <= ST_WDATA;
                            wr_en <= 1'b1; wr_idx <= idx; wr_data <= shreg;
                            if (idx != IDX_END) idx <= idx + 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // R11
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));
    // R10
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/ctl_regfile.sv
// Control register bank: masked storage of writable bits, live pin
// mirrors, fixed signature and zeroed reserved bits on readback.
// Assumes wr_en is a single-cycle pulse from the engine.
module ctl_regfile
    import clkgen_ctl_pkg::*;
#(
    parameter int unsigned NBYTES = REG_BYTES,
    parameter int unsigned IDXW   = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_data,
    input  logic [2:0]        fsel_pin,
    input  logic              cpu_stop_n_pin,
    input  logic              pci_stop_n_pin,
    input  logic              mult_pin,
    output logic [NBYTES*8-1:0] cfg_image,
    output logic              pci_clk_run
);
    logic [7:0] store [NBYTES];
    logic [7:0] view  [NBYTES];

    assign pci_clk_run = store[0][3] & pci_stop_n_pin;

    for (genvar g = 0; g < NBYTES; g++) begin : g_reg
        // Masked storage for register g.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  store[g] <= rst_val(g) & wmask(g);
            else if (wr_en && wr_idx == IDXW'(g))        store[g] <= wr_data & wmask(g);
        end
        assign cfg_image[8*g +: 8] = store[g];

        if (g == 0) begin : g_view0
            assign view[g] = {store[g][7:5], cpu_stop_n_pin, pci_clk_run, fsel_pin};
        end else if (g == 1) begin : g_view1
            assign view[g] = {mult_pin, store[g][6:0]};
        end else if (g == SIG_INDEX) begin : g_viewsig
            assign view[g] = SIG_VALUE;
        end else begin : g_viewst
            assign view[g] = store[g];
        end
    end

    // Readback select; indices past the bank read zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NBYTES; i++)
            if (rd_idx == IDXW'(i)) rd_data = view[i];
    end

    // R2
    no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_image));
    // R8
    past_end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDXW'(NBYTES)) |=> $stable(cfg_image));
endmodule

// File: rtl/clkgen_ctl_slave.sv
// Top of the clock generator control slave: line synchronizer, block
// transfer engine and register bank, plus decoded PLL fields.
// Assumes NBYTES is at least 10 so the PLL registers exist.
module clkgen_ctl_slave
    import clkgen_ctl_pkg::*;
#(
    parameter int unsigned NBYTES = REG_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [2:0]          fsel_pin,
    input  logic                cpu_stop_n_pin,
    input  logic                pci_stop_n_pin,
    input  logic                mult_pin,
    output logic [NBYTES*8-1:0] cfg_image,
    output logic                pci_clk_run,
    output logic                pll_custom,
    output logic [6:0]          pll_n,
    output logic [5:0]          pll_r
);
    localparam int unsigned IDXW = $clog2(NBYTES + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [IDXW-1:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    smb_block_engine #(.NBYTES(NBYTES), .IDXW(IDXW)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data));

    ctl_regfile #(.NBYTES(NBYTES), .IDXW(IDXW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .fsel_pin(fsel_pin),
        .cpu_stop_n_pin(cpu_stop_n_pin), .pci_stop_n_pin(pci_stop_n_pin),
        .mult_pin(mult_pin), .cfg_image(cfg_image), .pci_clk_run(pci_clk_run));

    assign pll_custom = cfg_image[9*8];
    assign pll_n      = cfg_image[8*8 +: 7];
    assign pll_r      = cfg_image[9*8+1 +: 6];
endmodule

// File: tb/clkgen_ctl_slave_test.sv
`timescale 1ns/1ps
module clkgen_ctl_slave_test;
    localparam int Q = 10;
    localparam int NB = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_low = 1'b0;
    logic [2:0] fsel = 3'b101;
    logic cpu_n = 1'b1, pci_n = 1'b1, mult = 1'b1;
    logic sda_oe, pci_clk_run, pll_custom;
    logic [NB*8-1:0] cfg_image;
    logic [6:0] pll_n;
    logic [5:0] pll_r;
    wire sda_line = ~(m_low | sda_oe);

    int errors = 0, checks = 0;
    logic [7:0] mdl [NB];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #10 clk = ~clk;

    clkgen_ctl_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .fsel_pin(fsel), .cpu_stop_n_pin(cpu_n), .pci_stop_n_pin(pci_n), .mult_pin(mult),
        .cfg_image(cfg_image), .pci_clk_run(pci_clk_run), .pll_custom(pll_custom),
        .pll_n(pll_n), .pll_r(pll_r));

    function automatic logic [7:0] bm(int i);
        case (i)
            0: return 8'hE8; 1: return 8'h7F; 2: return 8'hFF; 3: return 8'hFF;
            4: return 8'hBF; 5: return 8'hF5; 8: return 8'h7F; 9: return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(int i);
        if (i >= NB) return 8'h00;
        if (i == 0) return {mdl[0][7:5], cpu_n, mdl[0][3] & pci_n, fsel};
        if (i == 1) return {mult, mdl[1][6:0]};
        if (i == 6) return 8'h13;
        return mdl[i];
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(logic b);
        m_low = ~b; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q/2);
        ack = ~sda_line;
        tick(Q/2); m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(logic nack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(Q); m_scl = 1'b1; tick(Q/2);
            b = {b[6:0], sda_line};
            tick(Q/2); m_scl = 1'b0;
        end
        tick(Q); m_low = ~nack; tick(Q); m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q); m_low = 1'b0;
    endtask

    // Full block write of n bytes from wbuf; updates the model.
    task automatic do_write(int n, string req);
        logic ack;
        bus_start();
        send_byte(8'hD2, ack); chk({req, " addr ack"}, ack, 1);
        send_byte(8'h5A, ack); chk({req, " cmd ack"}, ack, 1);
        send_byte(8'(n), ack); chk({req, " count ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk($sformatf("%s data%0d ack", req, i), ack, 1);
            if (i < NB) mdl[i] = wbuf[i] & bm(i);
        end
        bus_stop();
    endtask

    // Block read of n bytes into rbuf, comparing each to the model.
    task automatic do_read(int n, string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack); chk({req, " rd addr ack R1"}, ack, 1);
        recv_byte(1'b0, b); chk({req, " count byte R3"}, b, NB);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            rbuf[i] = b;
            chk($sformatf("%s reg%0d", req, i), b, exp_rd(i));
        end
        chk({req, " released after NACK R3"}, sda_line, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        mdl[0] = 8'h00; mdl[1] = 8'h07; mdl[2] = 8'h7F; mdl[3] = 8'hC7; mdl[4] = 8'h3F;
        mdl[5] = 8'h40; mdl[6] = 8'h00; mdl[7] = 8'h00; mdl[8] = 8'h00; mdl[9] = 8'h00;
        chk("R7 sda idle", sda_line, 1);
        chk("R7 pll_custom", pll_custom, 0);
        chk("R5 pci_clk_run reset", pci_clk_run, 0);
        chk("R7 image reg3", cfg_image[31:24], 8'hC7);
        do_read(NB, "R7 defaults");
    endtask

    task automatic t_write_order();
        for (int i = 0; i < 6; i++) wbuf[i] = 8'h11 * (i + 3);
        do_write(6, "R2 ordered write");
        do_read(6, "R2 readback");
        chk("R2 image reg2", cfg_image[23:16], 8'h55);
    endtask

    task automatic t_pins();
        wbuf[0] = 8'h17; wbuf[1] = 8'h80;
        fsel = 3'b010; cpu_n = 1'b0; mult = 1'b0;
        do_write(2, "R4 write ro bits");
        do_read(2, "R4 pin mirror");
        chk("R4 reg0 value", rbuf[0], 8'h02);
        fsel = 3'b101; cpu_n = 1'b1; mult = 1'b1;
        do_read(2, "R4 pin mirror 2");
    endtask

    task automatic t_pci_and();
        wbuf[0] = 8'h08; do_write(1, "R5 set bit");
        pci_n = 1'b1; tick(2);
        chk("R5 run with pin high", pci_clk_run, 1);
        do_read(1, "R5 read and high");
        pci_n = 1'b0; tick(2);
        chk("R5 run with pin low", pci_clk_run, 0);
        do_read(1, "R5 read and low");
        chk("R5 bit3 low", rbuf[0][3], 0);
        pci_n = 1'b1; tick(2);
        chk("R5 stored kept", pci_clk_run, 1);
    endtask

    task automatic t_ones();
        for (int i = 0; i < 12; i++) wbuf[i] = 8'hFF;
        do_write(12, "R8 all ones past end");
        do_read(12, "R8 reserved and past end");
        chk("R6 signature", rbuf[6], 8'h13);
        chk("R8 reg4", rbuf[4], 8'hBF);
        chk("R8 reg5", rbuf[5], 8'hF5);
        chk("R8 reg7", rbuf[7], 8'h00);
        chk("R8 reg10", rbuf[10], 8'h00);
    endtask

    task automatic t_pll();
        for (int i = 0; i < 8; i++) wbuf[i] = mdl[i];
        wbuf[6] = 8'hAA; wbuf[8] = 8'h55; wbuf[9] = 8'h2B;
        do_write(10, "R9 pll regs");
        tick(2);
        chk("R9 pll_custom", pll_custom, 1);
        chk("R9 pll_n", pll_n, 7'h55);
        chk("R9 pll_r", pll_r, 6'h15);
        do_read(10, "R6 sig after write");
    endtask

    task automatic t_bad_addr();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); chk("R1 foreign addr nack", ack, 0);
        send_byte(8'h00, ack); chk("R1 following byte nack", ack, 0);
        send_byte(8'h00, ack);
        bus_stop();
        bus_start();
        send_byte(8'hD4, ack); chk("R1 near addr nack", ack, 0);
        send_byte(8'h00, ack); send_byte(8'h01, ack); send_byte(8'h00, ack);
        bus_stop();
        do_read(3, "R1 no change");
    endtask

    task automatic t_abort();
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h04, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        do_read(1, "R10 partial byte dropped");
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h01, ack);
        send_byte(8'h20, ack); chk("R10 data ack", ack, 1);
        mdl[0] = 8'h20;
        bus_start();
        send_byte(8'hD3, ack); chk("R10 restart addr ack", ack, 1);
        recv_byte(1'b0, b); chk("R10 restart count", b, NB);
        recv_byte(1'b1, b); chk("R10 restart reg0", b, exp_rd(0));
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(5); rst_n = 1'b1; tick(5);
        t_reset();
        t_write_order();
        t_pins();
        t_pci_and();
        t_ones();
        t_pll();
        t_bad_addr();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule